// File: doc/BRIEF.md
# Three-Port Registered Bus Exchanger

This block moves 16-bit words between three symmetric ports, A, B and C. Each port owns one storage element. The element can pass its input straight through (transparent), keep its last value (held), or take a new value on the rising edge of that port's own clock when clock capture is enabled. Every port drives an output word taken from the storage element of one of the two other ports. As a result, live data or stored data can be moved from any port to one or both of the others.

The pad tristate is split into three parts per port: an input word, an output word and an output-enable flag. A system integrator connects these to the bidirectional pad cell. Each port runs only from its own clock, latch enable and clock enable. The three clocks are independent of each other. An asynchronous active-low reset clears all three storage elements.

Top module: `tri_port_exchanger`

## Requirements
- R1: While `rst_n` is low, all three stored words are zero, whatever the other inputs do. An enabled port then outputs 0x0000.
- R2: While `latch_en[i]` is 1, port i is transparent. Its stored word equals its input word with no clock edge, and a routed output follows input changes at once.
- R3: While `latch_en[i]` is 0 and `port_clk[i]` does not rise, the stored word does not change when the input word changes. The value present when `latch_en[i]` fell is kept.
- R4: When `latch_en[i]` is 0 and `clk_en_n[i]` is 0, a rising edge of `port_clk[i]` loads the input word into the storage element.
- R5: When `latch_en[i]` is 0 and `clk_en_n[i]` is 1, a rising edge of `port_clk[i]` leaves the stored word unchanged.
- R6: `oe_n[i]` is active low. When it is 1, `out_en[i]` is 0 and the output word is 0x0000. When it is 0, `out_en[i]` is 1.
- R7: Bit i of every control vector belongs to port i, with A at bit 0, B at bit 1 and C at bit 2. An enabled port i outputs the stored word of port (i+1) mod 3 when `sel[i]`=0, and of port (i+2) mod 3 when `sel[i]`=1. So A takes B or C, B takes C or A, and C takes A or B. One port may feed both of the other ports at the same time.
- R8: The storage of a port reacts only to its own clock, latch enable and clock enable. A clock edge on another port never loads it.
- R9: A port whose output is disabled still loads and holds its storage as R2 to R5 describe, so another port can read that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all storage |
| port_clk | input | 3 | Per-port capture clock, bit 0 = A |
| latch_en | input | 3 | Per-port transparency control, 1 = transparent |
| clk_en_n | input | 3 | Per-port active-low edge-capture enable |
| sel | input | 3 | Per-port source pick between the two other ports |
| oe_n | input | 3 | Per-port active-low output enable |
| din_a | input | 16 | Input word of port A |
| din_b | input | 16 | Input word of port B |
| din_c | input | 16 | Input word of port C |
| dout_a | output | 16 | Output word of port A, zero when disabled |
| dout_b | output | 16 | Output word of port B, zero when disabled |
| dout_c | output | 16 | Output word of port C, zero when disabled |
| out_en | output | 3 | Per-port pad drive enable, the inverse of oe_n |

## Verification
The routing is tried with all three ports transparent and a different word on each input. The select values cover both full rotations and the mixed cases where one source feeds both other ports, so a wrong source index shows up as the wrong word. Enable masks with one, two or all three ports disabled show whether output gating is applied per port and leaves the routing of the other ports intact. The storage is then stepped through these sequences:
- closing the latch while the input changes afterwards;
- a clock edge with capture enabled and a clock edge with capture disabled;
- a clock edge on a foreign port;
- capture on a disabled port;
- a reset in the middle of the run.

Each of these separates transparent, held, captured and ignored behaviour.

// File: rtl/xchg_pkg.sv
`timescale 1ns/1ps
package xchg_pkg;

    localparam int NPORT = 3;

    // Source port for a given port and select bit: rotate by one or by two.
    function automatic int src_port(input int self, input logic pick);
        return (self + 1 + (pick ? 1 : 0)) % NPORT;
    endfunction

endpackage

// File: rtl/xchg_cell.sv
`timescale 1ns/1ps
// One storage element: master/slave latch pair. Both halves open while
// latch_en is high, which gives transparency. Otherwise the master tracks
// while the clock is low and the slave opens on the high phase if capture is enabled.
module xchg_cell #(
    parameter int W = 16
) (
    input  logic         rst_n,
    input  logic         clk,
    input  logic         le,
    input  logic         ce_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic mst;
        logic slv;
    } gate_t;

    gate_t       open_d;
    logic [W-1:0] mst_q;
    logic [W-1:0] slv_q;

    always_comb begin
        open_d.mst = le | ~clk;
        open_d.slv = le | (clk & ~ce_n);
    end

    always_latch begin
        if (!rst_n)
            mst_q <= '0;
        else if (open_d.mst)
            mst_q <= din;
    end

    always_latch begin
        if (!rst_n)
            slv_q <= '0;
        else if (open_d.slv)
            slv_q <= mst_q;
    end

    assign q = slv_q;

endmodule

// File: rtl/xchg_route.sv
`timescale 1ns/1ps
// Output path of one port: choose a neighbour's stored word, gate by enable.
module xchg_route
    import xchg_pkg::*;
#(
    parameter int W    = 16,
    parameter int SELF = 0
) (
    input  logic [NPORT-1:0][W-1:0] stor_all,
    input  logic                    pick,
    input  logic                    oe_n,
    output logic [W-1:0]            dout,
    output logic                    en
);

    localparam int SRC0 = src_port(SELF, 1'b0);
    localparam int SRC1 = src_port(SELF, 1'b1);

    logic [W-1:0] chosen_d;

    always_comb begin
        chosen_d = pick ? stor_all[SRC1] : stor_all[SRC0];
        en       = ~oe_n;
        dout     = en ? chosen_d : '0;
    end

endmodule

// File: rtl/tri_port_exchanger.sv
`timescale 1ns/1ps
module tri_port_exchanger
    import xchg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             rst_n,
    input  logic [NPORT-1:0] port_clk,
    input  logic [NPORT-1:0] latch_en,
    input  logic [NPORT-1:0] clk_en_n,
    input  logic [NPORT-1:0] sel,
    input  logic [NPORT-1:0] oe_n,
    input  logic [W-1:0]     din_a,
    input  logic [W-1:0]     din_b,
    input  logic [W-1:0]     din_c,
    output logic [W-1:0]     dout_a,
    output logic [W-1:0]     dout_b,
    output logic [W-1:0]     dout_c,
    output logic [NPORT-1:0] out_en
);

    logic [NPORT-1:0][W-1:0] din_v;
    logic [NPORT-1:0][W-1:0] stor_v;
    logic [NPORT-1:0][W-1:0] dout_v;

    assign din_v[0] = din_a;
    assign din_v[1] = din_b;
    assign din_v[2] = din_c;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        xchg_cell #(.W(W)) u_cell (
            .rst_n (rst_n),
            .clk   (port_clk[g]),
            .le    (latch_en[g]),
            .ce_n  (clk_en_n[g]),
            .din   (din_v[g]),
            .q     (stor_v[g])
        );

        xchg_route #(.W(W), .SELF(g)) u_route (
            .stor_all (stor_v),
            .pick     (sel[g]),
            .oe_n     (oe_n[g]),
            .dout     (dout_v[g]),
            .en       (out_en[g])
        );
    end

    assign dout_a = dout_v[0];
    assign dout_b = dout_v[1];
    assign dout_c = dout_v[2];

endmodule

// File: rtl/xchg_chk.sv
`timescale 1ns/1ps
module xchg_chk
    import xchg_pkg::*;
#(
    parameter int W = 16
) (
    input logic                    rst_n,
    input logic [NPORT-1:0]        port_clk,
    input logic [NPORT-1:0]        latch_en,
    input logic [NPORT-1:0]        clk_en_n,
    input logic [NPORT-1:0]        sel,
    input logic [NPORT-1:0]        oe_n,
    input logic [NPORT-1:0][W-1:0] din_v,
    input logic [NPORT-1:0][W-1:0] stor_v,
    input logic [NPORT-1:0][W-1:0] dout_v,
    input logic [NPORT-1:0]        out_en
);

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        localparam int S0 = src_port(i, 1'b0);
        localparam int S1 = src_port(i, 1'b1);

        logic         cap_seen_q, keep_seen_q;
        logic [W-1:0] cap_val_q, keep_val_q;

        always_ff @(posedge port_clk[i] or negedge rst_n) begin
            if (!rst_n) begin
                cap_seen_q  <= 1'b0;
                keep_seen_q <= 1'b0;
                cap_val_q   <= '0;
                keep_val_q  <= '0;
            end else begin
                cap_seen_q  <= !latch_en[i] && !clk_en_n[i];
                keep_seen_q <= !latch_en[i] &&  clk_en_n[i];
                cap_val_q   <= din_v[i];
                keep_val_q  <= stor_v[i];
            end
        end

        AST_TRANSPARENT_PATH: assert property (@(posedge port_clk[i]) disable iff (!rst_n)
            latch_en[i] |-> stor_v[i] == din_v[i]); // R2

        AST_EDGE_LOADS: assert property (@(negedge port_clk[i]) disable iff (!rst_n)
            (cap_seen_q && !latch_en[i]) |-> stor_v[i] == cap_val_q); // R4

        AST_EDGE_BLOCKED: assert property (@(negedge port_clk[i]) disable iff (!rst_n)
            (keep_seen_q && !latch_en[i]) |-> stor_v[i] == keep_val_q); // R5

        AST_DISABLED_QUIET: assert property (@(posedge port_clk[i]) disable iff (!rst_n)
            oe_n[i] |-> (!out_en[i] && dout_v[i] == '0)); // R6

        AST_ROUTE_NEAR: assert property (@(posedge port_clk[i]) disable iff (!rst_n)
            (out_en[i] && !sel[i]) |-> dout_v[i] == stor_v[S0]); // R7

        AST_ROUTE_FAR: assert property (@(posedge port_clk[i]) disable iff (!rst_n)
            (out_en[i] && sel[i]) |-> dout_v[i] == stor_v[S1]); // R7
    end

endmodule

bind tri_port_exchanger xchg_chk #(.W(W)) u_chk (
    .rst_n    (rst_n),
    .port_clk (port_clk),
    .latch_en (latch_en),
    .clk_en_n (clk_en_n),
    .sel      (sel),
    .oe_n     (oe_n),
    .din_v    (din_v),
    .stor_v   (stor_v),
    .dout_v   (dout_v),
    .out_en   (out_en)
);

// File: tb/sim_tri_port_exchanger.sv
`timescale 1ns/1ps
module sim_tri_port_exchanger;

    typedef struct packed {
        logic [2:0]  sel;
        logic [2:0]  oen;
        logic [15:0] a, b, c;
        logic [15:0] ea, eb, ec;
    } vec_t;

    // Port A is bit 0. Transparent routing vectors with expected outputs.
    localparam vec_t VECS [8] = '{
        '{3'b000, 3'b000, 16'h1111, 16'h2222, 16'h3333, 16'h2222, 16'h3333, 16'h1111},
        '{3'b111, 3'b000, 16'h1111, 16'h2222, 16'h3333, 16'h3333, 16'h1111, 16'h2222},
        '{3'b101, 3'b000, 16'hAAAA, 16'h5555, 16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h5555},
        '{3'b010, 3'b000, 16'hFFFF, 16'h0000, 16'h8001, 16'h0000, 16'hFFFF, 16'hFFFF},
        '{3'b000, 3'b111, 16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 16'h0000, 16'h0000},
        '{3'b000, 3'b101, 16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 16'h9ABC, 16'h0000},
        '{3'b110, 3'b010, 16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hBEEF, 16'h0000, 16'hBEEF},
        '{3'b001, 3'b000, 16'h0001, 16'h8000, 16'h7FFE, 16'h7FFE, 16'h7FFE, 16'h0001}
    };

    logic        sys_clk = 1'b0;
    logic        rst_n;
    logic [2:0]  pen, latch_en, clk_en_n, sel, oe_n, out_en, port_clk;
    logic [15:0] din_a, din_b, din_c, dout_a, dout_b, dout_c;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 sys_clk = ~sys_clk;
    assign port_clk = {3{sys_clk}} & pen;

    tri_port_exchanger #(.W(16)) u0 (
        .rst_n(rst_n), .port_clk(port_clk), .latch_en(latch_en),
        .clk_en_n(clk_en_n), .sel(sel), .oe_n(oe_n),
        .din_a(din_a), .din_b(din_b), .din_c(din_c),
        .dout_a(dout_a), .dout_b(dout_b), .dout_c(dout_c), .out_en(out_en)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int idx);
        @(negedge sys_clk);
        pen[idx] = 1'b1;
        @(negedge sys_clk);
        pen = 3'b000;
        #2;
    endtask

    task automatic settle();
        @(negedge sys_clk);
        #2;
    endtask

    initial begin
        rst_n = 1'b0; pen = 3'b000; latch_en = 3'b000; clk_en_n = 3'b111;
        sel = 3'b000; oe_n = 3'b000;
        din_a = 16'hAAAA; din_b = 16'hBBBB; din_c = 16'hCCCC;
        #35;
        chk("R1 reset A", dout_a, 16'h0000);
        chk("R1 reset B", dout_b, 16'h0000);
        chk("R1 reset C", dout_c, 16'h0000);
        chk("R6 reset out_en", {13'd0, out_en}, 16'h0007);
        @(negedge sys_clk);
        rst_n = 1'b1;

        // Transparent routing table (R2, R6, R7)
        latch_en = 3'b111;
        foreach (VECS[k]) begin
            @(negedge sys_clk);
            sel = VECS[k].sel; oe_n = VECS[k].oen;
            din_a = VECS[k].a; din_b = VECS[k].b; din_c = VECS[k].c;
            #2;
            chk($sformatf("R7 vec%0d A", k), dout_a, VECS[k].ea);
            chk($sformatf("R7 vec%0d B", k), dout_b, VECS[k].eb);
            chk($sformatf("R7 vec%0d C", k), dout_c, VECS[k].ec);
            chk($sformatf("R6 vec%0d out_en", k), {13'd0, out_en}, {13'd0, ~VECS[k].oen});
        end

        // R3: close latches, then inputs change with no clock
        @(negedge sys_clk);
        latch_en = 3'b000;
        settle();
        din_a = 16'hFFFF; din_b = 16'hFFFF; din_c = 16'hFFFF;
        sel = 3'b010; oe_n = 3'b000;
        #2;
        chk("R3 hold B<-A", dout_b, 16'h0001);
        chk("R3 hold A<-B", dout_a, 16'h8000);
        chk("R3 hold C<-A", dout_c, 16'h0001);

        // R4: edge capture on port A
        clk_en_n = 3'b110; din_a = 16'hABCD;
        pulse(0);
        chk("R4 capture A seen at B", dout_b, 16'hABCD);
        chk("R8 B untouched by A clock", dout_a, 16'h8000);

        // R5: capture disabled, edge ignored
        clk_en_n = 3'b111; din_a = 16'h5A5A;
        pulse(0);
        chk("R5 edge ignored A", dout_b, 16'hABCD);

        // R8: clock B only; A has capture enabled but no edge
        clk_en_n = 3'b100; din_a = 16'h9999; din_b = 16'h7777;
        pulse(1);
        chk("R8 B captured", dout_a, 16'h7777);
        chk("R8 A not loaded by B clock", dout_b, 16'hABCD);

        // R9: disabled port A still captures
        clk_en_n = 3'b110; oe_n = 3'b001; din_a = 16'h4321;
        pulse(0);
        chk("R9 disabled A captured", dout_b, 16'h4321);
        chk("R6 disabled A zero", dout_a, 16'h0000);
        chk("R6 disabled A out_en", {15'd0, out_en[0]}, 16'h0000);

        // R2: port C transparent without clock, then closes (R3)
        @(negedge sys_clk);
        clk_en_n = 3'b111; oe_n = 3'b000; sel = 3'b000;
        latch_en = 3'b100; din_c = 16'h0C0C;
        #2;
        chk("R2 transparent C", dout_b, 16'h0C0C);
        din_c = 16'h0D0D;
        #2;
        chk("R2 follows C", dout_b, 16'h0D0D);
        @(negedge sys_clk);
        latch_en = 3'b000;
        #2;
        din_c = 16'h0E0E;
        #2;
        chk("R3 C keeps closing value", dout_b, 16'h0D0D);

        // R1: asynchronous reset mid-run
        @(negedge sys_clk);
        rst_n = 1'b0;
        #2;
        chk("R1 async clear C", dout_b, 16'h0000);
        chk("R1 async clear A", dout_c, 16'h0000);
        @(negedge sys_clk);
        rst_n = 1'b1;
        settle();
        chk("R1 stays clear after release", dout_a, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge sys_clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule